// File: doc/BRIEF.md
# Nine-Bit Asynchronous Serial Port

This block is the serial transmitter and receiver of a small microcontroller. It carries two asynchronous framings. The first is a 10-bit frame: a low start bit, eight data bits with the least significant bit first, and a high stop bit. Its bit rate comes from an external timer that pulses `baud_tick` at sixteen times the bit rate. The second is an 11-bit frame that adds a programmable ninth bit before the stop bit. Its bit rate is derived from the core clock, at one bit per 32 clocks, or one bit per 16 clocks when `dbl` is set.

A one-cycle pulse on `tx_wr` loads `tx_data`, plus the ninth bit in the 11-bit framing, and starts a frame on `txd`. `ti` is raised in the cycle the stop bit appears on the line. The receiver samples `rxd` sixteen times per bit and starts on a falling edge. It checks the start bit again at mid-bit and samples each later bit at its centre. At the stop-bit sample it either accepts the frame into `rx_data` and `rx_bit9` and raises `ri`, or drops the frame without any trace. Software clears both flags with `ti_clr` and `ri_clr`.

Top module: `sio9_port`

## Requirements
- R1: After reset, `txd` is 1, `ti` and `ri` are 0, and `rx_data` and `rx_bit9` are 0.
- R2: With `mode_sel` = 2'b01, a write sends a 10-bit frame on `txd`: a 0 start bit, `tx_data` with the least significant bit first, then a 1 stop bit. Each bit lasts 16 `baud_tick` pulses.
- R3: With `mode_sel` = 2'b10, a write sends an 11-bit frame: a 0 start bit, eight data bits with the least significant bit first, then `tx_bit9` as sampled at the write, then a 1 stop bit. Each bit lasts 32 clocks, or 16 clocks when `dbl` = 1.
- R4: `ti` rises in the cycle the stop bit appears on `txd` and is 0 during the preceding bits. A write while a frame is in flight is ignored.
- R5: With `rx_en` = 1, a falling edge on `rxd` starts reception. When the frame is accepted, `rx_data` holds the eight data bits (least significant bit received first) and `ri` is set. `rx_bit9` holds the ninth bit in the 11-bit framing and the stop bit in the 10-bit framing.
- R6: A frame that completes while `ri` = 1 is dropped, and `rx_data` and `rx_bit9` keep their values.
- R7: A frame whose stop bit samples 0 is dropped, and `ri` stays 0.
- R8: With `mp_en` = 1 in the 11-bit framing, a frame whose ninth bit is 0 is dropped, and a frame whose ninth bit is 1 is accepted.
- R9: A low pulse on `rxd` that has ended by the middle of the start bit is a false start. It sets no flag, and the receiver accepts the next valid frame.
- R10: With `rx_en` = 0, a falling edge on `rxd` starts no reception.
- R11: With `mode_sel` = 2'b00 or 2'b11, writes are ignored (`txd` stays 1, `ti` stays 0) and no reception starts.
- R12: A pulse on `ti_clr` or `ri_clr` clears the matching flag by the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial receive line, idle high |
| baud_tick | input | 1 | Timer pulse at 16x bit rate, used in the 10-bit framing |
| mode_sel | input | 2 | Framing select: 01 = 10-bit, 10 = 11-bit, other codes inactive |
| dbl | input | 1 | Doubles the fixed rate of the 11-bit framing |
| tx_bit9 | input | 1 | Ninth bit to send in the 11-bit framing |
| mp_en | input | 1 | Accept only frames whose ninth bit is 1 |
| rx_en | input | 1 | Enables recognition of start edges |
| tx_wr | input | 1 | Transmit buffer write strobe |
| tx_data | input | 8 | Byte to send |
| ti_clr | input | 1 | Clears the transmit flag |
| ri_clr | input | 1 | Clears the receive flag |
| txd | output | 1 | Serial transmit line |
| rx_data | output | 8 | Receive buffer |
| rx_bit9 | output | 1 | Received ninth or stop bit |
| ti | output | 1 | Transmit flag |
| ri | output | 1 | Receive flag |

## Verification
The assertions check four things on every cycle. `ti` only rises while `txd` is high. A frame only starts after a write. The receive buffer moves only when `ri` rises, and only after a high stop-bit sample. In address-filter mode an accepted frame always carries a ninth bit of 1. The bench scenarios are needed for the rest: the exact bit order and bit length of both framings at both fixed rates, the rejection of frames arriving while `ri` is set, false-start recovery, and the silence of the inactive mode codes and of a disabled receiver.

// File: rtl/sio9_pkg.sv
package sio9_pkg;

    localparam int OVS = 16;

    typedef enum logic [1:0] {
        MODE_OFF0   = 2'b00,
        MODE_TEN    = 2'b01,
        MODE_ELEVEN = 2'b10,
        MODE_OFF3   = 2'b11
    } sio_mode_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_SHIFT
    } rx_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       bit9;
    } rx_frame_t;

    function automatic logic mode_active(input logic [1:0] m);
        return (m == MODE_TEN) || (m == MODE_ELEVEN);
    endfunction

    // index of the stop bit within a transmitted frame, start bit at 0
    function automatic logic [3:0] tx_last(input logic eleven);
        return eleven ? 4'd10 : 4'd9;
    endfunction

    // index of the stop sample among received samples, first data bit at 0
    function automatic logic [3:0] rx_last(input logic eleven);
        return eleven ? 4'd9 : 4'd8;
    endfunction

endpackage

// File: rtl/sio9_baudgen.sv
module sio9_baudgen
    import sio9_pkg::*;
#(
    parameter int FIX_DIV = 32,
    parameter int OVR     = OVS
) (
    input  logic clk,
    input  logic rst,
    input  logic eleven,
    input  logic dbl,
    input  logic ext_tick,
    output logic tick
);
    localparam int PER = FIX_DIV / OVR;
    localparam int CW  = (PER > 1) ? $clog2(PER) : 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;
    logic          fix_tick;

    assign lim      = dbl ? CW'(PER / 2 - 1) : CW'(PER - 1);
    assign fix_tick = (cnt == lim);
    assign tick     = eleven ? fix_tick : ext_tick;

    always_ff @(posedge clk) begin
        if (rst || !eleven) begin
            cnt <= '0;
        end else if (fix_tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sio9_tx.sv
module sio9_tx
    import sio9_pkg::*;
#(
    parameter int OVR = OVS
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic [1:0] mode,
    input  logic       wr,
    input  logic [7:0] data,
    input  logic       bit9,
    input  logic       ti_clr,
    output logic       txd,
    output logic       ti,
    output logic       busy
);
    localparam int TW = $clog2(OVR);

    logic [10:0]   sh;
    logic [3:0]    idx;
    logic [3:0]    last;
    logic [TW-1:0] tcnt;
    logic          eleven;

    assign eleven = (mode == MODE_ELEVEN);
    assign txd    = busy ? sh[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '1;
            idx  <= '0;
            last <= '0;
            tcnt <= '0;
            busy <= 1'b0;
            ti   <= 1'b0;
        end else begin
            if (ti_clr) begin
                ti <= 1'b0;
            end
            if (!busy) begin
                if (wr && mode_active(mode)) begin
                    sh   <= {1'b1, (eleven ? bit9 : 1'b1), data, 1'b0};
                    last <= tx_last(eleven);
                    idx  <= '0;
                    tcnt <= '0;
                    busy <= 1'b1;
                end
            end else if (tick) begin
                if (tcnt == TW'(OVR - 1)) begin
                    tcnt <= '0;
                    if (idx == last) begin
                        busy <= 1'b0;
                    end else begin
                        sh  <= {1'b1, sh[10:1]};
                        idx <= idx + 1'b1;
                        if (4'(idx + 1'b1) == last) begin
                            ti <= 1'b1;
                        end
                    end
                end else begin
                    tcnt <= tcnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sio9_rx.sv
module sio9_rx
    import sio9_pkg::*;
#(
    parameter int OVR = OVS
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic [1:0] mode,
    input  logic       rx_en,
    input  logic       mp_en,
    input  logic       rxd,
    input  logic       ri_clr,
    output logic [7:0] rx_data,
    output logic       rb9,
    output logic       ri,
    output logic       line_s
);
    localparam int TW   = $clog2(OVR);
    localparam int HALF = OVR / 2;

    logic [1:0]    sync;
    logic          prev;
    rx_state_e     state;
    logic [TW-1:0] tcnt;
    logic [3:0]    idx;
    logic [9:0]    sh;
    logic          eleven;
    rx_frame_t     fr;
    logic          accept;

    assign line_s  = sync[1];
    assign fr.data = eleven ? sh[8:1] : sh[9:2];
    assign fr.bit9 = eleven ? sh[9] : line_s;
    assign accept  = !ri && line_s && (!mp_en || fr.bit9);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync    <= 2'b11;
            prev    <= 1'b1;
            state   <= RX_IDLE;
            tcnt    <= '0;
            idx     <= '0;
            sh      <= '0;
            eleven  <= 1'b0;
            rx_data <= '0;
            rb9     <= 1'b0;
            ri      <= 1'b0;
        end else begin
            sync <= {sync[0], rxd};
            prev <= line_s;
            if (ri_clr) begin
                ri <= 1'b0;
            end
            case (state)
                RX_IDLE: begin
                    if (rx_en && mode_active(mode) && prev && !line_s) begin
                        state  <= RX_START;
                        tcnt   <= '0;
                        idx    <= '0;
                        eleven <= (mode == MODE_ELEVEN);
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (tcnt == TW'(HALF - 1)) begin
                            tcnt  <= '0;
                            state <= line_s ? RX_IDLE : RX_SHIFT;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                RX_SHIFT: begin
                    if (tick) begin
                        if (tcnt == TW'(OVR - 1)) begin
                            tcnt <= '0;
                            if (idx == rx_last(eleven)) begin
                                state <= RX_IDLE;
                                if (accept) begin
                                    rx_data <= fr.data;
                                    rb9     <= fr.bit9;
                                    ri      <= 1'b1;
                                end
                            end else begin
                                sh  <= {line_s, sh[9:1]};
                                idx <= idx + 1'b1;
                            end
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sio9_port.sv
module sio9_port
    import sio9_pkg::*;
#(
    parameter int FIX_DIV = 32,
    parameter int OVR     = OVS
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rxd,
    input  logic       baud_tick,
    input  logic [1:0] mode_sel,
    input  logic       dbl,
    input  logic       tx_bit9,
    input  logic       mp_en,
    input  logic       rx_en,
    input  logic       tx_wr,
    input  logic [7:0] tx_data,
    input  logic       ti_clr,
    input  logic       ri_clr,
    output logic       txd,
    output logic [7:0] rx_data,
    output logic       rx_bit9,
    output logic       ti,
    output logic       ri
);
    logic tick;
    logic tx_busy;
    logic rx_line;

    sio9_baudgen #(.FIX_DIV(FIX_DIV), .OVR(OVR)) u_baud (
        .clk      (clk),
        .rst      (rst),
        .eleven   (mode_sel == MODE_ELEVEN),
        .dbl      (dbl),
        .ext_tick (baud_tick),
        .tick     (tick)
    );

    sio9_tx #(.OVR(OVR)) u_tx (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .mode   (mode_sel),
        .wr     (tx_wr),
        .data   (tx_data),
        .bit9   (tx_bit9),
        .ti_clr (ti_clr),
        .txd    (txd),
        .ti     (ti),
        .busy   (tx_busy)
    );

    sio9_rx #(.OVR(OVR)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .mode    (mode_sel),
        .rx_en   (rx_en),
        .mp_en   (mp_en),
        .rxd     (rxd),
        .ri_clr  (ri_clr),
        .rx_data (rx_data),
        .rb9     (rx_bit9),
        .ri      (ri),
        .line_s  (rx_line)
    );
endmodule

// File: rtl/sio9_port_chk.sv
module sio9_port_chk (
    input logic       clk,
    input logic       rst,
    input logic       txd,
    input logic       ti,
    input logic       ri,
    input logic       ti_clr,
    input logic       ri_clr,
    input logic       tx_wr,
    input logic       tx_busy,
    input logic       rx_line,
    input logic [7:0] rx_data,
    input logic       rx_bit9,
    input logic       mp_en
);
    AST_TI_ON_STOP: assert property (@(posedge clk) disable iff (rst)
        $rose(ti) |-> txd);                                        // R4
    AST_TX_STARTS_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_busy) |-> $past(tx_wr));                          // R2
    AST_RX_STOP_HIGH: assert property (@(posedge clk) disable iff (rst)
        $rose(ri) |-> $past(rx_line));                             // R7
    AST_RX_BUF_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$rose(ri) |-> ($stable(rx_data) && $stable(rx_bit9)));     // R6
    AST_RX_ADDR_NINTH: assert property (@(posedge clk) disable iff (rst)
        ($rose(ri) && $past(mp_en)) |-> rx_bit9);                  // R8
    AST_RI_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (ri && ri_clr) |=> !ri);                                   // R12
    AST_TI_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (ti && ti_clr && !tx_busy) |=> !ti);                       // R12
endmodule

bind sio9_port sio9_port_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .txd     (txd),
    .ti      (ti),
    .ri      (ri),
    .ti_clr  (ti_clr),
    .ri_clr  (ri_clr),
    .tx_wr   (tx_wr),
    .tx_busy (tx_busy),
    .rx_line (rx_line),
    .rx_data (rx_data),
    .rx_bit9 (rx_bit9),
    .mp_en   (mp_en)
);

// File: tb/sio9_port_bench.sv
module sio9_port_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rxd = 1'b1;
    logic       baud_tick = 1'b0;
    logic [1:0] mode_sel = 2'b10;
    logic       dbl = 1'b1;
    logic       tx_bit9 = 1'b0;
    logic       mp_en = 1'b0;
    logic       rx_en = 1'b1;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_data = '0;
    logic       ti_clr = 1'b0;
    logic       ri_clr = 1'b0;
    logic       txd;
    logic [7:0] rx_data;
    logic       rx_bit9;
    logic       ti;
    logic       ri;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    sio9_port u_sio9_port (
        .clk(clk), .rst(rst), .rxd(rxd), .baud_tick(baud_tick),
        .mode_sel(mode_sel), .dbl(dbl), .tx_bit9(tx_bit9), .mp_en(mp_en),
        .rx_en(rx_en), .tx_wr(tx_wr), .tx_data(tx_data), .ti_clr(ti_clr),
        .ri_clr(ri_clr), .txd(txd), .rx_data(rx_data), .rx_bit9(rx_bit9),
        .ti(ti), .ri(ri)
    );

    always #5 clk = ~clk;

    // external timer: one pulse every 4 clocks, so a 10-bit-mode bit is 64 clocks
    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            div = (div + 1) % 4;
            baud_tick = (div == 0);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] d);
        @(negedge clk);
        tx_wr = 1'b1;
        tx_data = d;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic pulse_clr(input bit t, input bit r);
        @(negedge clk);
        ti_clr = t;
        ri_clr = r;
        @(negedge clk);
        ti_clr = 1'b0;
        ri_clr = 1'b0;
    endtask

    task automatic tx_frame(input logic [1:0] m, input logic d, input logic [7:0] data,
                            input logic b9, input int per, input string tag);
        logic [7:0] got;
        int guard;
        mode_sel = m;
        dbl = d;
        tx_bit9 = b9;
        pulse_clr(1'b1, 1'b0);
        do_write(data);
        guard = 0;
        while (txd !== 1'b0 && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        wait_cyc(per / 2);
        chk(txd === 1'b0, {tag, " start bit"}, txd, 0);
        for (int i = 0; i < 8; i++) begin
            wait_cyc(per);
            got[i] = txd;
        end
        chk(got === data, {tag, " data bits"}, got, data);
        if (m == 2'b10) begin
            wait_cyc(per);
            chk(txd === b9, {tag, " ninth bit"}, txd, b9);
        end
        chk(ti === 1'b0, "R4 ti low before stop", ti, 0);
        wait_cyc(per);
        chk(txd === 1'b1, {tag, " stop bit"}, txd, 1);
        chk(ti === 1'b1, "R4 ti at stop", ti, 1);
        wait_cyc(per);
    endtask

    task automatic send_frame(input logic [7:0] data, input logic b9, input logic stop,
                              input bit eleven, input int per);
        @(negedge clk);
        rxd = 1'b0;
        wait_cyc(per);
        for (int i = 0; i < 8; i++) begin
            rxd = data[i];
            wait_cyc(per);
        end
        if (eleven) begin
            rxd = b9;
            wait_cyc(per);
        end
        rxd = stop;
        wait_cyc(per);
        rxd = 1'b1;
        wait_cyc(per);
    endtask

    task automatic t_reset;
        chk(txd === 1'b1, "R1 txd", txd, 1);
        chk(ti === 1'b0, "R1 ti", ti, 0);
        chk(ri === 1'b0, "R1 ri", ri, 0);
        chk(rx_data === 8'h00, "R1 rx_data", rx_data, 0);
        chk(rx_bit9 === 1'b0, "R1 rx_bit9", rx_bit9, 0);
    endtask

    task automatic t_tx_busy_write;
        int lows = 0;
        fork
            tx_frame(2'b10, 1'b1, 8'h3C, 1'b1, 16, "R4 busy");
            begin
                wait_cyc(40);
                tx_wr = 1'b1;
                tx_data = 8'hFF;
                @(negedge clk);
                tx_wr = 1'b0;
            end
        join
        for (int i = 0; i < 48; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
        chk(lows == 0, "R4 write while busy ignored", lows, 0);
    endtask

    task automatic t_rx_basic;
        mode_sel = 2'b10;
        dbl = 1'b1;
        send_frame(8'hA5, 1'b0, 1'b1, 1'b1, 16);
        chk(ri === 1'b1, "R5 ri set", ri, 1);
        chk(rx_data === 8'hA5, "R5 data", rx_data, 8'hA5);
        chk(rx_bit9 === 1'b0, "R5 ninth", rx_bit9, 0);
        send_frame(8'h5A, 1'b1, 1'b1, 1'b1, 16);
        chk(rx_data === 8'hA5, "R6 data kept while ri set", rx_data, 8'hA5);
        chk(rx_bit9 === 1'b0, "R6 ninth kept", rx_bit9, 0);
        pulse_clr(1'b0, 1'b1);
        chk(ri === 1'b0, "R12 ri cleared", ri, 0);
        dbl = 1'b0;
        send_frame(8'h81, 1'b1, 1'b1, 1'b1, 32);
        chk(ri === 1'b1 && rx_data === 8'h81, "R5 slow rate data", rx_data, 8'h81);
        chk(rx_bit9 === 1'b1, "R5 slow rate ninth", rx_bit9, 1);
        pulse_clr(1'b0, 1'b1);
        dbl = 1'b1;
    endtask

    task automatic t_rx_reject;
        send_frame(8'h33, 1'b1, 1'b0, 1'b1, 16);
        chk(ri === 1'b0, "R7 bad stop dropped", ri, 0);
        mp_en = 1'b1;
        send_frame(8'h44, 1'b0, 1'b1, 1'b1, 16);
        chk(ri === 1'b0, "R8 ninth 0 dropped", ri, 0);
        send_frame(8'h45, 1'b1, 1'b1, 1'b1, 16);
        chk(ri === 1'b1 && rx_data === 8'h45, "R8 ninth 1 accepted", rx_data, 8'h45);
        mp_en = 1'b0;
        pulse_clr(1'b0, 1'b1);
    endtask

    task automatic t_false_start;
        @(negedge clk);
        rxd = 1'b0;
        wait_cyc(3);
        rxd = 1'b1;
        wait_cyc(64);
        chk(ri === 1'b0, "R9 false start no flag", ri, 0);
        send_frame(8'h96, 1'b0, 1'b1, 1'b1, 16);
        chk(ri === 1'b1 && rx_data === 8'h96, "R9 recovery frame", rx_data, 8'h96);
        pulse_clr(1'b0, 1'b1);
    endtask

    task automatic t_rx_disabled;
        rx_en = 1'b0;
        send_frame(8'h11, 1'b1, 1'b1, 1'b1, 16);
        chk(ri === 1'b0, "R10 disabled receiver", ri, 0);
        chk(rx_data === 8'h96, "R10 buffer untouched", rx_data, 8'h96);
        rx_en = 1'b1;
    endtask

    task automatic t_rx_ten;
        mode_sel = 2'b01;
        send_frame(8'hC3, 1'b0, 1'b1, 1'b0, 64);
        chk(ri === 1'b1 && rx_data === 8'hC3, "R5 10-bit data", rx_data, 8'hC3);
        chk(rx_bit9 === 1'b1, "R5 10-bit stop in rx_bit9", rx_bit9, 1);
        pulse_clr(1'b0, 1'b1);
    endtask

    task automatic t_inactive(input logic [1:0] m);
        int lows = 0;
        mode_sel = m;
        pulse_clr(1'b1, 1'b1);
        do_write(8'h00);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
        chk(lows == 0 && ti === 1'b0, "R11 write ignored", lows, 0);
        send_frame(8'h22, 1'b1, 1'b1, 1'b1, 16);
        chk(ri === 1'b0, "R11 no reception", ri, 0);
        mode_sel = 2'b10;
    endtask

    initial begin
        wait_cyc(4);
        rst = 1'b0;
        wait_cyc(2);
        t_reset();
        tx_frame(2'b01, 1'b0, 8'hB4, 1'b0, 64, "R2");
        tx_frame(2'b10, 1'b0, 8'h6D, 1'b1, 32, "R3 slow");
        tx_frame(2'b10, 1'b1, 8'h92, 1'b0, 16, "R3 fast");
        pulse_clr(1'b1, 1'b0);
        chk(ti === 1'b0, "R12 ti cleared", ti, 0);
        t_tx_busy_write();
        t_rx_basic();
        t_rx_reject();
        t_false_start();
        t_rx_disabled();
        t_rx_ten();
        t_inactive(2'b00);
        t_inactive(2'b11);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule